// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core and handles the moment the core accepts an event. Whenever the core raises a one-cycle take strobe, the sequencer looks at the pending synchronous exception and at the external interrupt request. It decides which of the two, if either, is accepted. For an accepted event it performs the whole entry in that single clock: it saves the status word, program counter and stack register into shadow registers and records the event code. It then raises privilege in the status word and computes the new program counter from the vector base.

The core supplies its live status word, program counter, register 15, vector base and delay-slot flags as inputs. It reads back the updated status word, the shadow copies, the event code registers, the new program counter and the cleaned flags once the one-cycle taken pulse appears. An external priority controller receives the current interrupt mask on `imask_o` and answers with a vector and a valid flag. When the status word's block bit is set, exceptions are escalated to a reset-class entry, and interrupts are held off unless the core is waking from halt.

Top module: `evt_entry_seq`

## Requirements
- R1: After reset every registered output is zero and neither `taken_o` nor `halt_clr_o` is asserted.
- R2: Without an accepted event, the status, shadow, code and PC outputs keep their values and `taken_o` stays low; an exception-valid input without `take_i` has no effect.
- R3: A pending exception wins over an interrupt request at the same take; `taken_exc_o` is 1 and the interrupt-event output keeps its old value.
- R4: With status bit 28 (block) set, an accepted exception of any code except 0x1E0 is recorded as code 0x000 and handled as reset-class; code 0x1E0 keeps its own code.
- R5: With status bit 28 set, an interrupt-only take is ignored unless `halt_wake_i` is 1; `halt_clr_o` pulses for one cycle on every take with bit 28 set except such an ignored interrupt.
- R6: `imask_o` always equals status bits 7:4; an interrupt is accepted only when `irq_vec_valid_i` is 1 at the take, otherwise nothing changes.
- R7: On acceptance the saved status gets the input status, the saved register 15 gets `r15_i`, and the new status is the input status with bits 28, 29 and 30 set.
- R8: If flag bit 0 or bit 1 is set the saved PC is PC−2 and flag bits 2:0 are cleared; if flag bit 3 is set all flags are cleared; otherwise saved PC is PC and flags are returned unchanged.
- R9: Exception codes 0x000, 0x020 and 0x140 clear status bit 15, force status bits 7:4 to 0xF and set the new PC to 0xA0000000.
- R10: Exception codes 0x040 and 0x060 jump to VBR+0x400; all other non-reset-class exceptions jump to VBR+0x100.
- R11: Exception code 0x160 adds 2 to the saved PC after any delay-slot rewind.
- R12: An accepted interrupt writes its vector to the interrupt-event output, sets PC to VBR+0x600 and leaves the exception-event output unchanged.
- R13: `taken_o` is a one-cycle pulse in the cycle after an accepted take, with `taken_exc_o` 1 for an exception and 0 for an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| take_i | input | 1 | One-cycle strobe: core is ready to take an event |
| exc_valid_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_req_i | input | 1 | External interrupt request |
| irq_vec_valid_i | input | 1 | Priority controller has a vector above the mask |
| irq_vec_i | input | 12 | Interrupt vector from the priority controller |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current register 15 |
| vbr_i | input | 32 | Vector base |
| flags_i | input | 4 | Delay-slot flags: bit0 slot, bit1 conditional slot, bit2 condition true, bit3 clear-all |
| halt_wake_i | input | 1 | Core is waking from halt |
| imask_o | output | 4 | Current interrupt mask for the priority controller |
| sr_o | output | 32 | Updated status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved register 15 |
| expevt_o | output | 12 | Last accepted exception code |
| intevt_o | output | 12 | Last accepted interrupt vector |
| pc_o | output | 32 | New program counter |
| flags_o | output | 4 | Delay-slot flags after entry |
| taken_o | output | 1 | One-cycle pulse: an event was accepted |
| taken_exc_o | output | 1 | Accepted event was an exception |
| halt_clr_o | output | 1 | One-cycle pulse: clear the halt-wakeup flag |

## Verification
Each code class is driven on its own: a generic code, both TLB-miss codes, the reset-class codes and the trap code. Each tells apart a different target address, status rewrite or saved-PC adjustment. Delay-slot flag patterns (slot, conditional with condition true, condition-true alone, clear-all, and trap inside a slot) separate the rewind from the flag clearing. Simultaneous exception and interrupt, interrupts with and without a valid vector, and block-bit takes with and without halt wakeup show priority, escalation to reset and masking. The 0x1E0 code under the block bit shows the one code that escapes escalation.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int XLEN   = 32;
    localparam int CODE_W = 12;
    localparam int FLAG_W = 4;
    localparam int MASK_W = 4;

    localparam logic [CODE_W-1:0] CODE_POWERON = 12'h000;
    localparam logic [CODE_W-1:0] CODE_MANUAL  = 12'h020;
    localparam logic [CODE_W-1:0] CODE_MULTHIT = 12'h140;
    localparam logic [CODE_W-1:0] CODE_MISS_RD = 12'h040;
    localparam logic [CODE_W-1:0] CODE_MISS_WR = 12'h060;
    localparam logic [CODE_W-1:0] CODE_TRAP    = 12'h160;
    localparam logic [CODE_W-1:0] CODE_NOBLOCK = 12'h1E0;

    typedef struct packed {
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   ssr;
        logic [XLEN-1:0]   spc;
        logic [XLEN-1:0]   sgr;
        logic [CODE_W-1:0] expevt;
        logic [CODE_W-1:0] intevt;
        logic [XLEN-1:0]   pc;
        logic [FLAG_W-1:0] flags;
        logic              taken;
        logic              taken_exc;
        logic              halt_clr;
    } seq_state_t;

    function automatic logic is_reset_class(input logic [CODE_W-1:0] c);
        return (c == CODE_POWERON) || (c == CODE_MANUAL) || (c == CODE_MULTHIT);
    endfunction

    function automatic logic is_miss_class(input logic [CODE_W-1:0] c);
        return (c == CODE_MISS_RD) || (c == CODE_MISS_WR);
    endfunction
endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
    import evt_pkg::*;
(
    input  logic              take_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              irq_vec_valid_i,
    input  logic [CODE_W-1:0] irq_vec_i,
    input  logic              blocked_i,
    input  logic              halt_wake_i,
    output logic              accept_o,
    output logic              is_exc_o,
    output logic [CODE_W-1:0] code_o,
    output logic              halt_clr_o
);
    logic want_irq;
    logic irq_held;

    always_comb begin
        // an interrupt competes only when no exception is pending
        want_irq = irq_req_i && !exc_valid_i;
        irq_held = blocked_i && want_irq && !halt_wake_i;

        accept_o   = 1'b0;
        is_exc_o   = 1'b0;
        code_o     = '0;
        halt_clr_o = take_i && blocked_i && !irq_held;

        if (take_i) begin
            if (exc_valid_i) begin
                accept_o = 1'b1;
                is_exc_o = 1'b1;
                if (blocked_i && (exc_code_i != CODE_NOBLOCK)) begin
                    code_o = CODE_POWERON;
                end else begin
                    code_o = exc_code_i;
                end
            end else if (want_irq && !irq_held && irq_vec_valid_i) begin
                accept_o = 1'b1;
                code_o   = irq_vec_i;
            end
        end
    end
endmodule

// File: rtl/evt_target.sv
module evt_target
    import evt_pkg::*;
#(
    parameter int              BL_BIT    = 28,
    parameter int              RB_BIT    = 29,
    parameter int              MD_BIT    = 30,
    parameter int              FD_BIT    = 15,
    parameter int              MASK_LSB  = 4,
    parameter logic [XLEN-1:0] RESET_PC  = 32'hA000_0000,
    parameter logic [XLEN-1:0] OFS_GEN   = 32'h0000_0100,
    parameter logic [XLEN-1:0] OFS_MISS  = 32'h0000_0400,
    parameter logic [XLEN-1:0] OFS_IRQ   = 32'h0000_0600,
    parameter int              INSN_BYTES = 2
)(
    input  logic              is_exc_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic in_slot;

    always_comb begin
        in_slot = flags_i[0] || flags_i[1];

        sr_o         = sr_i;
        sr_o[BL_BIT] = 1'b1;
        sr_o[MD_BIT] = 1'b1;
        sr_o[RB_BIT] = 1'b1;

        spc_o   = pc_i;
        flags_o = flags_i;
        if (in_slot) begin
            spc_o        = pc_i - STEP;
            flags_o[2:0] = 3'b000;
        end
        if (flags_i[3]) begin
            flags_o = '0;
        end

        if (is_exc_i) begin
            if (is_reset_class(code_i)) begin
                sr_o[FD_BIT]                = 1'b0;
                sr_o[MASK_LSB +: MASK_W]    = '1;
                pc_o                        = RESET_PC;
            end else if (is_miss_class(code_i)) begin
                pc_o = vbr_i + OFS_MISS;
            end else begin
                pc_o = vbr_i + OFS_GEN;
            end
            if (code_i == CODE_TRAP) begin
                spc_o = spc_o + STEP;
            end
        end else begin
            pc_o = vbr_i + OFS_IRQ;
        end
    end
endmodule

// File: rtl/evt_entry_seq.sv
module evt_entry_seq
    import evt_pkg::*;
#(
    parameter int BL_BIT   = 28,
    parameter int RB_BIT   = 29,
    parameter int MD_BIT   = 30,
    parameter int FD_BIT   = 15,
    parameter int MASK_LSB = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              irq_vec_valid_i,
    input  logic [CODE_W-1:0] irq_vec_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   r15_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              halt_wake_i,
    output logic [MASK_W-1:0] imask_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   sgr_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              taken_o,
    output logic              taken_exc_o,
    output logic              halt_clr_o
);
    seq_state_t state_d, state_q;

    logic              acc;
    logic              acc_exc;
    logic [CODE_W-1:0] acc_code;
    logic              hclr;
    logic [XLEN-1:0]   tgt_sr;
    logic [XLEN-1:0]   tgt_spc;
    logic [XLEN-1:0]   tgt_pc;
    logic [FLAG_W-1:0] tgt_flags;

    evt_arbiter u_arb (
        .take_i          (take_i),
        .exc_valid_i     (exc_valid_i),
        .exc_code_i      (exc_code_i),
        .irq_req_i       (irq_req_i),
        .irq_vec_valid_i (irq_vec_valid_i),
        .irq_vec_i       (irq_vec_i),
        .blocked_i       (sr_i[BL_BIT]),
        .halt_wake_i     (halt_wake_i),
        .accept_o        (acc),
        .is_exc_o        (acc_exc),
        .code_o          (acc_code),
        .halt_clr_o      (hclr)
    );

    evt_target #(
        .BL_BIT   (BL_BIT),
        .RB_BIT   (RB_BIT),
        .MD_BIT   (MD_BIT),
        .FD_BIT   (FD_BIT),
        .MASK_LSB (MASK_LSB)
    ) u_tgt (
        .is_exc_i (acc_exc),
        .code_i   (acc_code),
        .sr_i     (sr_i),
        .pc_i     (pc_i),
        .vbr_i    (vbr_i),
        .flags_i  (flags_i),
        .sr_o     (tgt_sr),
        .spc_o    (tgt_spc),
        .pc_o     (tgt_pc),
        .flags_o  (tgt_flags)
    );

    always_comb begin
        state_d           = state_q;
        state_d.taken     = 1'b0;
        state_d.taken_exc = 1'b0;
        state_d.halt_clr  = hclr;
        if (acc) begin
            state_d.ssr       = sr_i;
            state_d.sgr       = r15_i;
            state_d.sr        = tgt_sr;
            state_d.spc       = tgt_spc;
            state_d.pc        = tgt_pc;
            state_d.flags     = tgt_flags;
            state_d.taken     = 1'b1;
            state_d.taken_exc = acc_exc;
            if (acc_exc) begin
                state_d.expevt = acc_code;
            end else begin
                state_d.intevt = acc_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign imask_o     = sr_i[MASK_LSB +: MASK_W];
    assign sr_o        = state_q.sr;
    assign ssr_o       = state_q.ssr;
    assign spc_o       = state_q.spc;
    assign sgr_o       = state_q.sgr;
    assign expevt_o    = state_q.expevt;
    assign intevt_o    = state_q.intevt;
    assign pc_o        = state_q.pc;
    assign flags_o     = state_q.flags;
    assign taken_o     = state_q.taken;
    assign taken_exc_o = state_q.taken_exc;
    assign halt_clr_o  = state_q.halt_clr;
endmodule

// File: rtl/evt_entry_seq_chk.sv
module evt_entry_seq_chk
    import evt_pkg::*;
#(
    parameter int BL_BIT = 28,
    parameter int RB_BIT = 29,
    parameter int MD_BIT = 30
)(
    input logic              clk,
    input logic              rst_n,
    input logic              take_i,
    input logic              exc_valid_i,
    input logic [CODE_W-1:0] exc_code_i,
    input logic              irq_vec_valid_i,
    input logic [XLEN-1:0]   sr_i,
    input logic [XLEN-1:0]   r15_i,
    input logic [XLEN-1:0]   vbr_i,
    input logic              halt_wake_i,
    input logic [XLEN-1:0]   sr_o,
    input logic [XLEN-1:0]   ssr_o,
    input logic [XLEN-1:0]   sgr_o,
    input logic [CODE_W-1:0] expevt_o,
    input logic [XLEN-1:0]   pc_o,
    input logic              taken_o,
    input logic              taken_exc_o
);
    // R13: a taken pulse only follows a take strobe
    assert_taken_after_take_R13: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> $past(take_i));

    // R2: without an accepted event the PC and exception code hold
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> ($stable(pc_o) && $stable(expevt_o)));

    // R3: a pending exception is always the event taken
    assert_exc_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && $past(exc_valid_i)) |-> taken_exc_o);

    // R4: block bit escalates exceptions other than 0x1E0
    assert_block_escalates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && taken_exc_o && $past(sr_i[BL_BIT]) && ($past(exc_code_i) != CODE_NOBLOCK))
        |-> (expevt_o == CODE_POWERON));

    // R5: under the block bit an interrupt needs halt wakeup
    assert_block_irq_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && !taken_exc_o && $past(sr_i[BL_BIT])) |-> $past(halt_wake_i));

    // R6: an interrupt needs a valid vector
    assert_irq_vec_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && !taken_exc_o) |-> $past(irq_vec_valid_i));

    // R7: context save and privilege raise
    assert_context_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> ((ssr_o == $past(sr_i)) && (sgr_o == $past(r15_i))
                     && sr_o[BL_BIT] && sr_o[MD_BIT] && sr_o[RB_BIT]));

    // R12: interrupt entry address
    assert_irq_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && !taken_exc_o) |-> (pc_o == ($past(vbr_i) + 32'h0000_0600)));
endmodule

bind evt_entry_seq evt_entry_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .take_i          (take_i),
    .exc_valid_i     (exc_valid_i),
    .exc_code_i      (exc_code_i),
    .irq_vec_valid_i (irq_vec_valid_i),
    .sr_i            (sr_i),
    .r15_i           (r15_i),
    .vbr_i           (vbr_i),
    .halt_wake_i     (halt_wake_i),
    .sr_o            (sr_o),
    .ssr_o           (ssr_o),
    .sgr_o           (sgr_o),
    .expevt_o        (expevt_o),
    .pc_o            (pc_o),
    .taken_o         (taken_o),
    .taken_exc_o     (taken_exc_o)
);

// File: tb/evt_entry_seq_test.sv
module evt_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [11:0] exc_code_i = '0;
    logic        irq_req_i = 1'b0;
    logic        irq_vec_valid_i = 1'b0;
    logic [11:0] irq_vec_i = '0;
    logic [31:0] sr_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] r15_i = '0;
    logic [31:0] vbr_i = '0;
    logic [3:0]  flags_i = '0;
    logic        halt_wake_i = 1'b0;
    logic [3:0]  imask_o;
    logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
    logic [11:0] expevt_o, intevt_o;
    logic [3:0]  flags_o;
    logic        taken_o, taken_exc_o, halt_clr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    evt_entry_seq uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        take_i = 0; exc_valid_i = 0; exc_code_i = '0; irq_req_i = 0;
        irq_vec_valid_i = 0; irq_vec_i = '0; flags_i = '0; halt_wake_i = 0;
    endtask

    // drive a take at negedge, sample one negedge after the capturing edge
    task automatic take_once();
        take_i = 1'b1;
        @(negedge clk);
        take_i = 1'b0;
    endtask

    task automatic exc_case(input logic [11:0] code, input logic [31:0] sr,
                            input logic [31:0] pc, input logic [3:0] fl);
        @(negedge clk);
        idle_inputs();
        exc_valid_i = 1; exc_code_i = code; sr_i = sr; pc_i = pc;
        r15_i = pc ^ 32'h5A5A_0000; vbr_i = 32'h8000_0000; flags_i = fl;
        take_once();
        exc_valid_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 pc", pc_o, 0);
        chk("R1 sr", sr_o, 0);
        chk("R1 expevt", {20'd0, expevt_o}, 0);
        chk("R1 pulses", {29'd0, taken_o, taken_exc_o, halt_clr_o}, 0);
    endtask

    task automatic t_no_take();
        @(negedge clk);
        idle_inputs();
        exc_valid_i = 1; exc_code_i = 12'h180; vbr_i = 32'h8000_0000;
        @(negedge clk); @(negedge clk);
        chk("R2 taken", {31'd0, taken_o}, 0);
        chk("R2 pc", pc_o, 0);
        exc_valid_i = 0;
    endtask

    task automatic t_general();
        exc_case(12'h180, 32'h0000_00F0, 32'h0000_1000, 4'h0);
        chk("R13 taken", {30'd0, taken_o, taken_exc_o}, 32'h3);
        chk("R10 pc", pc_o, 32'h8000_0100);
        chk("R7 ssr", ssr_o, 32'h0000_00F0);
        chk("R7 sr", sr_o, 32'h7000_00F0);
        chk("R7 sgr", sgr_o, 32'h5A5A_1000);
        chk("R8 spc", spc_o, 32'h0000_1000);
        chk("R10 expevt", {20'd0, expevt_o}, 32'h180);
        @(negedge clk);
        chk("R13 pulse ends", {31'd0, taken_o}, 0);
        chk("R2 hold pc", pc_o, 32'h8000_0100);
    endtask

    task automatic t_miss();
        exc_case(12'h040, 32'h0, 32'h2000, 4'h0);
        chk("R10 miss rd pc", pc_o, 32'h8000_0400);
        exc_case(12'h060, 32'h0, 32'h2000, 4'h0);
        chk("R10 miss wr pc", pc_o, 32'h8000_0400);
    endtask

    task automatic t_reset_class();
        exc_case(12'h020, 32'h0000_8030, 32'h3000, 4'h0);
        chk("R9 pc", pc_o, 32'hA000_0000);
        chk("R9 sr", sr_o, 32'h7000_00F0);
        chk("R9 ssr", ssr_o, 32'h0000_8030);
        exc_case(12'h140, 32'h0000_8000, 32'h3000, 4'h0);
        chk("R9 multi pc", pc_o, 32'hA000_0000);
        chk("R9 multi sr", sr_o, 32'h7000_00F0);
    endtask

    task automatic t_trap();
        exc_case(12'h160, 32'h0, 32'h2000, 4'h0);
        chk("R11 spc", spc_o, 32'h2002);
        chk("R11 pc", pc_o, 32'h8000_0100);
        exc_case(12'h160, 32'h0, 32'h2000, 4'h1);
        chk("R11 slot spc", spc_o, 32'h2000);
        chk("R8 slot flags", {28'd0, flags_o}, 0);
    endtask

    task automatic t_slot();
        exc_case(12'h180, 32'h0, 32'h4000, 4'b0110);
        chk("R8 cond spc", spc_o, 32'h3FFE);
        chk("R8 cond flags", {28'd0, flags_o}, 0);
        exc_case(12'h180, 32'h0, 32'h4000, 4'b1000);
        chk("R8 clearall spc", spc_o, 32'h4000);
        chk("R8 clearall flags", {28'd0, flags_o}, 0);
        exc_case(12'h180, 32'h0, 32'h4000, 4'b0100);
        chk("R8 truebit spc", spc_o, 32'h4000);
        chk("R8 truebit flags", {28'd0, flags_o}, 4);
    endtask

    task automatic t_irq();
        logic [11:0] exp_before;
        exp_before = expevt_o;
        @(negedge clk);
        idle_inputs();
        sr_i = 32'h0000_0050; vbr_i = 32'h8C00_0000; pc_i = 32'h5000;
        r15_i = 32'h7777;
        irq_req_i = 1; irq_vec_valid_i = 0; irq_vec_i = 12'h3A0;
        #1 chk("R6 imask", {28'd0, imask_o}, 5);
        take_once();
        chk("R6 no vector", {31'd0, taken_o}, 0);
        chk("R6 pc held", pc_o, 32'h8000_0100);
        irq_vec_valid_i = 1;
        take_once();
        chk("R13 irq taken", {30'd0, taken_o, taken_exc_o}, 32'h2);
        chk("R12 intevt", {20'd0, intevt_o}, 32'h3A0);
        chk("R12 pc", pc_o, 32'h8C00_0600);
        chk("R12 expevt kept", {20'd0, expevt_o}, {20'd0, exp_before});
        chk("R7 irq sr", sr_o, 32'h7000_0050);
        irq_req_i = 0; irq_vec_valid_i = 0;
    endtask

    task automatic t_priority();
        logic [11:0] int_before;
        int_before = intevt_o;
        @(negedge clk);
        idle_inputs();
        sr_i = 32'h0; vbr_i = 32'h8000_0000; pc_i = 32'h6000;
        exc_valid_i = 1; exc_code_i = 12'h0E0;
        irq_req_i = 1; irq_vec_valid_i = 1; irq_vec_i = 12'h5C0;
        take_once();
        chk("R3 exc taken", {31'd0, taken_exc_o}, 1);
        chk("R3 expevt", {20'd0, expevt_o}, 32'h0E0);
        chk("R3 intevt kept", {20'd0, intevt_o}, {20'd0, int_before});
        idle_inputs();
    endtask

    task automatic t_block();
        exc_case(12'h180, 32'h1000_0050, 32'h7000, 4'h0);
        chk("R4 escalated code", {20'd0, expevt_o}, 0);
        chk("R4 reset pc", pc_o, 32'hA000_0000);
        chk("R4 sr", sr_o, 32'h7000_00F0);
        chk("R5 clr on exc", {31'd0, halt_clr_o}, 1);
        exc_case(12'h1E0, 32'h1000_0050, 32'h7000, 4'h0);
        chk("R4 1E0 code", {20'd0, expevt_o}, 32'h1E0);
        chk("R4 1E0 pc", pc_o, 32'h8000_0100);
        chk("R4 1E0 sr", sr_o, 32'h7000_0050);
        @(negedge clk);
        idle_inputs();
        sr_i = 32'h1000_0000; vbr_i = 32'h8100_0000;
        irq_req_i = 1; irq_vec_valid_i = 1; irq_vec_i = 12'h200;
        take_once();
        chk("R5 blocked irq", {31'd0, taken_o}, 0);
        chk("R5 no clr", {31'd0, halt_clr_o}, 0);
        chk("R5 pc held", pc_o, 32'h8000_0100);
        halt_wake_i = 1;
        take_once();
        chk("R5 wake irq", {31'd0, taken_o}, 1);
        chk("R5 wake clr", {31'd0, halt_clr_o}, 1);
        chk("R5 wake pc", pc_o, 32'h8100_0600);
        @(negedge clk);
        chk("R5 clr pulse ends", {31'd0, halt_clr_o}, 0);
        idle_inputs();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        t_no_take();
        t_general();
        t_miss();
        t_reset_class();
        t_trap();
        t_slot();
        t_irq();
        t_priority();
        t_block();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule